// File: doc/BRIEF.md
# Collapsing Instruction Queue

This block holds up to eight 32-bit instructions waiting for dispatch, with slot 0 always holding the oldest entry. Each cycle the cache side can deliver a burst of up to eight new instructions. The dispatcher sees every slot together with its per-slot flags: valid, bubble and FPU-dispatched.

In a single cycle the dispatcher may remove any mix of entries from the lower four slots, which form the dispatch window. The entries that are not removed slide down toward slot 0 and keep their relative order. The new arrivals are written directly above them. Instead of being removed, an entry in the window can be turned into a bubble (a no-op placeholder that keeps its position), and it can be tagged as already sent to the FPU.

The fetcher reads a free-slot count and a full flag and uses them to decide whether to request more instructions. A flush input, raised on a branch redirect, empties the queue.

Top module: `instr_queue8`

## Requirements
- R1: After reset every slot is invalid, `free_cnt` is 8 and `full` is 0.
- R2: The queue accepts min(`in_cnt`, slots free after this cycle's removals) new words. Word k of `in_data` (bits k*32+31..k*32) lands in the k-th slot above the survivors, and the surplus is dropped. `in_cnt` never exceeds 8.
- R3: Bit i of `rm_mask` (i = 0..3) removes slot i at the next edge if that slot is valid. A bit set on an invalid slot has no effect.
- R4: Surviving entries move down toward slot 0, keep their original order, and carry their data and flags with them.
- R5: Bit i of `bub_mask` (i = 0..3) sets the bubble flag of valid slot i, which keeps its data and its place in the order. If the same bit is also set in `rm_mask`, the removal wins.
- R6: Bit i of `fdisp_mask` (i = 0..3) sets the FPU-dispatched flag of valid slot i. This flag follows the same precedence rules as the bubble flag.
- R7: Newly enqueued entries start with the bubble and FPU-dispatched flags clear.
- R8: `free_cnt` equals 8 minus the number of valid slots, and `full` is 1 exactly when `free_cnt` is 0.
- R9: When `flush` is 1, every slot is invalid after the edge, and any enqueue, removal or marking in that same cycle is ignored.
- R10: The valid slots always form a contiguous run that starts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empties the queue on a redirect |
| in_cnt | input | 4 | Number of words offered in `in_data` (0..8) |
| in_data | input | 256 | Offered instructions, word k at bits k*32+31..k*32 |
| rm_mask | input | 4 | Per-slot removal of window slots 0..3 |
| bub_mask | input | 4 | Per-slot bubble conversion of window slots 0..3 |
| fdisp_mask | input | 4 | Per-slot FPU-dispatched marking of window slots 0..3 |
| slot_data | output | 256 | Slot contents, slot j at bits j*32+31..j*32 |
| slot_valid | output | 8 | Valid bit for each slot |
| slot_bubble | output | 8 | Bubble flag for each slot |
| slot_fpu | output | 8 | FPU-dispatched flag for each slot |
| free_cnt | output | 4 | Number of empty slots |
| full | output | 1 | No empty slot |

## Verification
The assertions assume that `in_cnt` is never larger than 8 and that every control input is a known value at each clock edge. The mask inputs may point at empty slots, and the assertions treat such bits as legitimate no-ops. The stimulus draws `in_cnt` only from 0 to 8, drives every input from the bench at the falling edge, and sets mask bits freely on empty and full slots alike. This exercises the precedence and the ignore rules without breaking the assumptions.

// File: rtl/instr_queue8.sv
module instr_queue8 #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  parameter int WIN   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [$clog2(DEPTH+1)-1:0] in_cnt,
  input  logic [DEPTH*WIDTH-1:0] in_data,
  input  logic [WIN-1:0]         rm_mask,
  input  logic [WIN-1:0]         bub_mask,
  input  logic [WIN-1:0]         fdisp_mask,
  output logic [DEPTH*WIDTH-1:0] slot_data,
  output logic [DEPTH-1:0]       slot_valid,
  output logic [DEPTH-1:0]       slot_bubble,
  output logic [DEPTH-1:0]       slot_fpu,
  output logic [$clog2(DEPTH+1)-1:0] free_cnt,
  output logic                   full
);
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] q_data [DEPTH];
  logic [DEPTH-1:0] q_vld, q_bub, q_fd;

  logic [WIDTH-1:0] n_data [DEPTH];
  logic [DEPTH-1:0] n_vld, n_bub, n_fd;
  logic [DEPTH-1:0] surv, mk_b, mk_f;
  logic [CW-1:0]    rank [DEPTH];
  logic [CW-1:0]    nsurv, room, acc, off;

  always_comb begin
    surv = q_vld;
    mk_b = q_bub;
    mk_f = q_fd;
    for (int i = 0; i < WIN; i++) begin
      if (rm_mask[i])    surv[i] = 1'b0;
      if (bub_mask[i])   mk_b[i] = 1'b1;
      if (fdisp_mask[i]) mk_f[i] = 1'b1;
    end

    nsurv = '0;
    for (int i = 0; i < DEPTH; i++) begin
      rank[i] = nsurv;
      if (surv[i]) nsurv = nsurv + CW'(1);
    end

    room = CW'(DEPTH) - nsurv;
    acc  = (in_cnt < room) ? in_cnt : room;

    n_vld = '0;
    n_bub = '0;
    n_fd  = '0;
    off   = '0;
    for (int j = 0; j < DEPTH; j++) begin
      n_data[j] = q_data[j];
      for (int i = 0; i < DEPTH; i++) begin
        if (surv[i] && rank[i] == CW'(j)) begin
          n_data[j] = q_data[i];
          n_vld[j]  = 1'b1;
          n_bub[j]  = mk_b[i];
          n_fd[j]   = mk_f[i];
        end
      end
      if (CW'(j) >= nsurv && CW'(j) < nsurv + acc) begin
        off       = CW'(j) - nsurv;
        n_data[j] = in_data[off*WIDTH +: WIDTH];
        n_vld[j]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld <= '0;
      q_bub <= '0;
      q_fd  <= '0;
      for (int j = 0; j < DEPTH; j++) q_data[j] <= '0;
    end else if (flush) begin
      q_vld <= '0;
      q_bub <= '0;
      q_fd  <= '0;
    end else begin
      q_vld <= n_vld;
      q_bub <= n_bub;
      q_fd  <= n_fd;
      for (int j = 0; j < DEPTH; j++) q_data[j] <= n_data[j];
    end
  end

  for (genvar j = 0; j < DEPTH; j++) begin : g_out
    assign slot_data[j*WIDTH +: WIDTH] = q_data[j];
  end

  assign slot_valid  = q_vld;
  assign slot_bubble = q_bub;
  assign slot_fpu    = q_fd;
  assign free_cnt    = CW'(DEPTH) - CW'($countones(q_vld));
  assign full        = (free_cnt == '0);

  p_cnt_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_cnt <= CW'(DEPTH));

  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> slot_valid == '0);

  p_valid_prefix_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid & (slot_valid + DEPTH'(1))) == '0);

  p_head_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && rm_mask == '0 && slot_valid[0])
    |=> slot_valid[0] && $stable(slot_data[WIDTH-1:0]));

  p_bubble_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && slot_valid[0] && bub_mask[0] && !rm_mask[0]) |=> slot_bubble[0]);

  p_fpu_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && slot_valid[0] && fdisp_mask[0] && !rm_mask[0]) |=> slot_fpu[0]);

  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rm_mask == '0 && !flush) |=> full && $stable(slot_valid));
endmodule

// File: tb/test_instr_queue8.sv
module test_instr_queue8;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush = 1'b0;
  logic [3:0]   in_cnt = '0;
  logic [255:0] in_data = '0;
  logic [3:0]   rm_mask = '0, bub_mask = '0, fdisp_mask = '0;
  logic [255:0] slot_data;
  logic [7:0]   slot_valid, slot_bubble, slot_fpu;
  logic [3:0]   free_cnt;
  logic         full;

  instr_queue8 i_instr_queue8 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_cnt(in_cnt), .in_data(in_data),
    .rm_mask(rm_mask), .bub_mask(bub_mask), .fdisp_mask(fdisp_mask),
    .slot_data(slot_data), .slot_valid(slot_valid), .slot_bubble(slot_bubble),
    .slot_fpu(slot_fpu), .free_cnt(free_cnt), .full(full));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] md[$];
  bit mb[$], mf[$];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    logic [7:0] ev;
    ev = '0;
    for (int j = 0; j < md.size(); j++) ev[j] = 1'b1;
    chk(tag, "valid", 64'(slot_valid), 64'(ev));
    chk(tag, "free", 64'(free_cnt), 64'(8 - md.size()));
    chk(tag, "full", 64'(full), 64'(md.size() == 8));
    for (int j = 0; j < md.size(); j++) begin
      chk(tag, $sformatf("data%0d", j), 64'(slot_data[j*32 +: 32]), 64'(md[j]));
      chk(tag, $sformatf("bubble%0d", j), 64'(slot_bubble[j]), 64'(mb[j]));
      chk(tag, $sformatf("fpu%0d", j), 64'(slot_fpu[j]), 64'(mf[j]));
    end
  endtask

  task automatic model_step();
    logic [31:0] nd[$];
    bit nb[$], nf[$];
    int acc;
    if (!flush) begin
      for (int i = 0; i < md.size(); i++) begin
        if (i < 4 && rm_mask[i]) continue;
        nd.push_back(md[i]);
        nb.push_back(mb[i] | (i < 4 && bub_mask[i]));
        nf.push_back(mf[i] | (i < 4 && fdisp_mask[i]));
      end
      acc = int'(in_cnt);
      if (acc > 8 - nd.size()) acc = 8 - nd.size();
      for (int k = 0; k < acc; k++) begin
        nd.push_back(in_data[k*32 +: 32]);
        nb.push_back(1'b0);
        nf.push_back(1'b0);
      end
    end
    md = nd; mb = nb; mf = nf;
  endtask

  task automatic cyc(string tag, int cnt, logic [3:0] rm, logic [3:0] bb,
                     logic [3:0] fd, bit fl);
    in_cnt = 4'(cnt); rm_mask = rm; bub_mask = bb; fdisp_mask = fd; flush = fl;
    for (int k = 0; k < 8; k++) in_data[k*32 +: 32] = $urandom;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    cyc("R2", 5, 0, 0, 0, 0);
    cyc("R2 R8", 6, 0, 0, 0, 0);
    cyc("R8", 3, 0, 0, 0, 0);
    cyc("R3 R4", 0, 4'b1010, 0, 0, 0);
    cyc("R5 R6", 0, 0, 4'b0010, 4'b0100, 0);
    cyc("R5 R6 precedence", 0, 4'b0001, 4'b0001, 4'b0001, 0);
    cyc("R4 flags", 0, 4'b0001, 0, 0, 0);
    cyc("R2 R4 R7", 4, 4'b0110, 0, 0, 0);
    cyc("R9", 8, 4'b1111, 4'b1111, 4'b1111, 1);
    cyc("R2", 2, 0, 0, 0, 0);
    cyc("R3 ignore", 0, 4'b1100, 4'b1000, 4'b1000, 0);
    cyc("R10", 8, 4'b0001, 0, 0, 0);
    for (int n = 0; n < 3000; n++)
      cyc("random R4 R10", $urandom_range(0, 8), 4'($urandom), 4'($urandom),
          4'($urandom), ($urandom_range(0, 40) == 0));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule